// File: doc/BRIEF.md
# Random Number Generator Register Peripheral

A memory-mapped peripheral that produces random words on request. Software writes commands over a simple 32-bit register bus with an address, a write strobe, write data and combinational read data. Two commands exist. One fills a bank of result words. The other mixes fresh entropy into the generator state. While either command runs, two busy flags in the status register show which one is active. Completion sets sticky flags that software clears by writing ones, and these flags can drive a maskable interrupt line.

The physical noise source is replaced by a free-running counter. Its value is folded into the generator state during a reseed. The generator itself is a 32-bit xorshift register (shift and exclusive-or feedback). A result bank holds either four or eight words, selected by a mode bit. A detector watches for the all-zero state, which the xorshift register can never leave on its own. When it sees that state it restarts the register from a fixed nonzero value and raises a lockup flag. The registers for the automatic reseed policies (by request count and by age) are plain storage with no effect on the block.

Top module: `rng_periph`

## Requirements
- R1: After reset, these registers read 0: status (0x04), mode (0x08), interrupt enable (0x10), interrupt status (0x14) and every result word (0x20 to 0x3C). The `irq` output is low after reset.
- R2: Writing 0x1 to control (0x00) while idle starts a generation. Status bit 30 is then high for exactly GEN_CYCLES clock cycles (default 16). At the end, interrupt status bit 0 (data ready) is set.
- R3: Writing 0x2 to control while idle starts a reseed. Status bit 31 is then high for exactly SEED_CYCLES cycles (default 8). At the end, interrupt status bit 1 (seed done) and status bit 9 (seeded) are set, and later results no longer follow the unseeded sequence.
- R4: Writing any other value to control (0x0, 0x3, and so on) starts nothing.
- R5: A control write made while bit 30 or bit 31 is high is ignored. The running job keeps its length, and the other job does not start.
- R6: Each generation step computes x ^= x<<13, x ^= x>>17, x ^= x<<5 on the 32-bit state, whose reset value is RESET_SEED. At completion, word i (at 0x20+4*i) holds the state produced by step GEN_CYCLES-i of that generation. Generating without a prior reseed continues from the reset seed.
- R7: Bit 3 of mode selects 8 result words when set and 4 when clear. Status bit 3 mirrors it. Result words at or above the active count read 0 under the current mode.
- R8: All result words change together at the completing edge. They hold their previous values for the whole time a generation is running.
- R9: Writing 1 to bit 0, 1 or 4 of interrupt status (0x14) clears that bit, and bits written as 0 are unchanged. A flag set on the same edge as its clear stays set.
- R10: Interrupt enable keeps only bits 0, 1, 4 and 31, and its other bits read 0. `irq` is high when bit 31 is set and, for at least one of bits 0, 1 and 4, both the enable bit and the status bit are set.
- R11: A generation step that finds the state all zero sets interrupt status bit 4 (lockup). It then takes LOCKUP_SEED as that step's output and continues the sequence from there.
- R12: Secondary mode (0x0C), auto-request count (0x60) and auto-age (0x64) are 32-bit read/write registers with no effect on status. The mode register keeps only bit 3.
- R13: Addresses with no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request, level |

## Verification
A wrong job counter shows as a busy bit whose high time is not 16 or 8 cycles. It is visible within one job. A state register that is stepped in the wrong order, or not stepped at all, changes every result word at the first completion, because the bench predicts the exact sequence from the reset seed. Bad bank latching shows as result words that move while bit 30 is still high. Faults in the flag and enable logic show at the next write to the interrupt registers, both in their readback and on `irq` one cycle later. A second instance with a zero reset seed exposes the lockup path at its first generation.

// File: rtl/rng_pkg.sv
package rng_pkg;

    localparam int WORD_W       = 32;
    localparam int WORDS_WIDE   = 8;
    localparam int WORDS_NARROW = 4;

    // register byte offsets
    localparam logic [7:0] ADDR_CTRL   = 8'h00;
    localparam logic [7:0] ADDR_STAT   = 8'h04;
    localparam logic [7:0] ADDR_MODE   = 8'h08;
    localparam logic [7:0] ADDR_SMODE  = 8'h0C;
    localparam logic [7:0] ADDR_IE     = 8'h10;
    localparam logic [7:0] ADDR_ISR    = 8'h14;
    localparam logic [7:0] ADDR_RES0   = 8'h20;
    localparam logic [7:0] ADDR_AUTORQ = 8'h60;
    localparam logic [7:0] ADDR_AGE    = 8'h64;

    // command codes
    localparam logic [WORD_W-1:0] CMD_GENERATE = 32'h1;
    localparam logic [WORD_W-1:0] CMD_RESEED   = 32'h2;

    // bit positions
    localparam int BIT_WIDE    = 3;
    localparam int BIT_SEEDED  = 9;
    localparam int BIT_GENBUSY = 30;
    localparam int BIT_SEEDBSY = 31;
    localparam int BIT_RDY     = 0;
    localparam int BIT_SDONE   = 1;
    localparam int BIT_LOCK    = 4;
    localparam int BIT_GLBL    = 31;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_GEN  = 2'd1,
        SEQ_SEED = 2'd2
    } seq_state_e;

    function automatic logic [WORD_W-1:0] xs_step(input logic [WORD_W-1:0] x);
        logic [WORD_W-1:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

endpackage

// File: rtl/rng_seq.sv
module rng_seq
    import rng_pkg::*;
#(
    parameter int GEN_CYCLES  = 16,
    parameter int SEED_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] cmd_code,
    output logic              generating_o,
    output logic              seeding_o,
    output logic              gen_done_o,
    output logic              seed_done_o
);

    localparam int MAX_CYC = (GEN_CYCLES > SEED_CYCLES) ? GEN_CYCLES : SEED_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } seq_regs_t;

    seq_regs_t q, d;
    logic      last_cycle;

    assign last_cycle = (q.cnt == CNT_W'(1));

    always_comb begin
        d = q;
        if (q.st == SEQ_IDLE) begin
            if (cmd_wr && (cmd_code == CMD_GENERATE)) begin
                d.st  = SEQ_GEN;
                d.cnt = CNT_W'(GEN_CYCLES);
            end else if (cmd_wr && (cmd_code == CMD_RESEED)) begin
                d.st  = SEQ_SEED;
                d.cnt = CNT_W'(SEED_CYCLES);
            end
        end else begin
            if (last_cycle) begin
                d.st  = SEQ_IDLE;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= SEQ_IDLE;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign generating_o = (q.st == SEQ_GEN);
    assign seeding_o    = (q.st == SEQ_SEED);
    assign gen_done_o   = generating_o && last_cycle;
    assign seed_done_o  = seeding_o && last_cycle;

    // a command during a generation does not end or replace it
    assert_busy_ignores_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SEQ_GEN && !last_cycle && cmd_wr) |=> (q.st == SEQ_GEN));

    assert_seed_ignores_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SEQ_SEED && !last_cycle && cmd_wr) |=> (q.st == SEQ_SEED));

endmodule

// File: rtl/rng_source.sv
module rng_source
    import rng_pkg::*;
#(
    parameter int                WORDS       = WORDS_WIDE,
    parameter logic [WORD_W-1:0] RESET_SEED  = 32'h1234_5678,
    parameter logic [WORD_W-1:0] LOCKUP_SEED = 32'h6A09_E667
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          step_gen,
    input  logic                          step_seed,
    input  logic                          gen_done,
    output logic [WORDS-1:0][WORD_W-1:0]  bank_o,
    output logic                          lockup_o
);

    typedef struct packed {
        logic [WORD_W-1:0]             state;
        logic [WORD_W-1:0]             noise;
        logic [WORDS-1:0][WORD_W-1:0]  shadow;
        logic [WORDS-1:0][WORD_W-1:0]  bank;
    } src_regs_t;

    src_regs_t         q, d;
    logic [WORD_W-1:0] fresh;
    logic              zero_state;

    assign zero_state = (q.state == '0);
    assign fresh      = zero_state ? LOCKUP_SEED : xs_step(q.state);

    always_comb begin
        d        = q;
        d.noise  = q.noise + WORD_W'(1);
        lockup_o = 1'b0;
        if (step_gen) begin
            lockup_o    = zero_state;
            d.state     = fresh;
            d.shadow[0] = fresh;
            for (int i = 1; i < WORDS; i++) begin
                d.shadow[i] = q.shadow[i-1];
            end
            if (gen_done) begin
                d.bank[0] = fresh;
                for (int i = 1; i < WORDS; i++) begin
                    d.bank[i] = q.shadow[i-1];
                end
            end
        end else if (step_seed) begin
            d.state = xs_step(q.state ^ q.noise);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state  <= RESET_SEED;
            q.noise  <= '0;
            q.shadow <= '0;
            q.bank   <= '0;
        end else begin
            q <= d;
        end
    end

    assign bank_o = q.bank;

    // a zero state never survives a generation step
    assert_lockup_recovers_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (step_gen && zero_state) |=> (q.state != '0));

endmodule

// File: rtl/rng_irq.sv
module rng_irq
    import rng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ie,
    input  logic              wr_isr,
    input  logic [3:0]        wbits,      // {glbl, lock, seed, ready} from write data
    input  logic              ev_ready,
    input  logic              ev_seed,
    input  logic              ev_lock,
    output logic [WORD_W-1:0] ie_o,
    output logic [WORD_W-1:0] isr_o,
    output logic              irq_o
);

    localparam int NSRC = 3;

    typedef struct packed {
        logic            glbl;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] pend;
    } irq_regs_t;

    irq_regs_t       q, d;
    logic [NSRC-1:0] events;

    assign events = {ev_lock, ev_seed, ev_ready};

    always_comb begin
        d = q;
        if (wr_ie) begin
            d.glbl = wbits[3];
            d.en   = wbits[2:0];
        end
        for (int k = 0; k < NSRC; k++) begin
            d.pend[k] = (q.pend[k] & ~(wr_isr & wbits[k])) | events[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        ie_o            = '0;
        ie_o[BIT_GLBL]  = q.glbl;
        ie_o[BIT_RDY]   = q.en[0];
        ie_o[BIT_SDONE] = q.en[1];
        ie_o[BIT_LOCK]  = q.en[2];
        isr_o            = '0;
        isr_o[BIT_RDY]   = q.pend[0];
        isr_o[BIT_SDONE] = q.pend[1];
        isr_o[BIT_LOCK]  = q.pend[2];
    end

    assign irq_o = q.glbl & |(q.en & q.pend);

    // a cleared flag with no new event reads low afterwards
    assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_isr && wbits[0] && !ev_ready) |=> !isr_o[BIT_RDY]);

    // an event always leaves its flag set, even against a clear
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ready |=> isr_o[BIT_RDY]);

endmodule

// File: rtl/rng_periph.sv
module rng_periph
    import rng_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                GEN_CYCLES  = 16,
    parameter int                SEED_CYCLES = 8,
    parameter logic [WORD_W-1:0] RESET_SEED  = 32'h1234_5678,
    parameter logic [WORD_W-1:0] LOCKUP_SEED = 32'h6A09_E667
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    localparam int IDX_W     = $clog2(WORDS_WIDE);
    localparam int BANK_SPAN = WORDS_WIDE * 4;

    typedef struct packed {
        logic              wide;
        logic              seeded;
        logic [WORD_W-1:0] smode;
        logic [WORD_W-1:0] auto_rq;
        logic [WORD_W-1:0] auto_age;
    } ctl_regs_t;

    ctl_regs_t q, d;

    logic wr_ctrl, wr_mode, wr_smode, wr_ie, wr_isr, wr_rq, wr_age;
    logic generating, seeding, gen_done, seed_done, lockup_evt;
    logic [WORDS_WIDE-1:0][WORD_W-1:0] bank;
    logic [WORD_W-1:0] ie_view, isr_view, stat_view;
    logic [ADDR_W-1:0] res_off;
    logic              res_hit;
    logic [IDX_W-1:0]  res_idx;
    logic [IDX_W:0]    active_words;

    // write decode
    assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
    assign wr_mode  = bus_wr && (bus_addr == ADDR_W'(ADDR_MODE));
    assign wr_smode = bus_wr && (bus_addr == ADDR_W'(ADDR_SMODE));
    assign wr_ie    = bus_wr && (bus_addr == ADDR_W'(ADDR_IE));
    assign wr_isr   = bus_wr && (bus_addr == ADDR_W'(ADDR_ISR));
    assign wr_rq    = bus_wr && (bus_addr == ADDR_W'(ADDR_AUTORQ));
    assign wr_age   = bus_wr && (bus_addr == ADDR_W'(ADDR_AGE));

    rng_seq #(
        .GEN_CYCLES (GEN_CYCLES),
        .SEED_CYCLES(SEED_CYCLES)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (wr_ctrl),
        .cmd_code    (bus_wdata),
        .generating_o(generating),
        .seeding_o   (seeding),
        .gen_done_o  (gen_done),
        .seed_done_o (seed_done)
    );

    rng_source #(
        .WORDS      (WORDS_WIDE),
        .RESET_SEED (RESET_SEED),
        .LOCKUP_SEED(LOCKUP_SEED)
    ) i_source (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_gen (generating),
        .step_seed(seeding),
        .gen_done (gen_done),
        .bank_o   (bank),
        .lockup_o (lockup_evt)
    );

    rng_irq i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ie   (wr_ie),
        .wr_isr  (wr_isr),
        .wbits   ({bus_wdata[BIT_GLBL], bus_wdata[BIT_LOCK],
                   bus_wdata[BIT_SDONE], bus_wdata[BIT_RDY]}),
        .ev_ready(gen_done),
        .ev_seed (seed_done),
        .ev_lock (lockup_evt),
        .ie_o    (ie_view),
        .isr_o   (isr_view),
        .irq_o   (irq)
    );

    // control and scratch registers
    always_comb begin
        d = q;
        if (wr_mode)   d.wide     = bus_wdata[BIT_WIDE];
        if (wr_smode)  d.smode    = bus_wdata;
        if (wr_rq)     d.auto_rq  = bus_wdata;
        if (wr_age)    d.auto_age = bus_wdata;
        if (seed_done) d.seeded   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // read path
    always_comb begin
        stat_view              = '0;
        stat_view[BIT_WIDE]    = q.wide;
        stat_view[BIT_SEEDED]  = q.seeded;
        stat_view[BIT_GENBUSY] = generating;
        stat_view[BIT_SEEDBSY] = seeding;
    end

    assign res_off      = bus_addr - ADDR_W'(ADDR_RES0);
    assign res_hit      = (bus_addr >= ADDR_W'(ADDR_RES0)) &&
                          (res_off < ADDR_W'(BANK_SPAN)) && (res_off[1:0] == 2'b00);
    assign res_idx      = res_off[IDX_W+1:2];
    assign active_words = q.wide ? (IDX_W+1)'(WORDS_WIDE) : (IDX_W+1)'(WORDS_NARROW);

    always_comb begin
        bus_rdata = '0;
        if (res_hit) begin
            if ({1'b0, res_idx} < active_words) begin
                bus_rdata = bank[res_idx];
            end
        end else begin
            case (bus_addr)
                ADDR_W'(ADDR_STAT):   bus_rdata = stat_view;
                ADDR_W'(ADDR_MODE):   bus_rdata = {28'd0, q.wide, 3'd0};
                ADDR_W'(ADDR_SMODE):  bus_rdata = q.smode;
                ADDR_W'(ADDR_IE):     bus_rdata = ie_view;
                ADDR_W'(ADDR_ISR):    bus_rdata = isr_view;
                ADDR_W'(ADDR_AUTORQ): bus_rdata = q.auto_rq;
                ADDR_W'(ADDR_AGE):    bus_rdata = q.auto_age;
                default:              bus_rdata = '0;
            endcase
        end
    end

    // end of a generation leaves the ready flag set
    assert_ready_after_gen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(generating) |-> isr_view[BIT_RDY]);

    // end of a reseed leaves the seeded status set
    assert_seeded_after_reseed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seeding) |-> q.seeded);

    // results hold until the completing edge
    assert_bank_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (generating && !gen_done) |=> $stable(bank));

    // only one job at a time
    assert_single_job_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({generating, seeding}));

endmodule

// File: tb/test_rng_periph.sv
module test_rng_periph;

    localparam logic [31:0] SEED0    = 32'h1234_5678;
    localparam logic [31:0] FALLBACK = 32'h6A09_E667;
    localparam int          GEN_N    = 16;
    localparam int          SEED_N   = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  addr;
    logic        wr;
    logic [31:0] wdata;
    logic [31:0] rdata, rdata_z;
    logic        irq, irq_z;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rng_periph i_rng_periph (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
    );

    rng_periph #(.RESET_SEED(32'h0)) i_rng_periph_zs (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rdata_z), .irq(irq_z)
    );

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y;
        if (x == 32'h0) return FALLBACK;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // word idx of a generation that starts from state st
    function automatic logic [31:0] word_after(input logic [31:0] st, input int idx);
        for (int k = 0; k < GEN_N - idx; k++) st = nxt(st);
        return st;
    endfunction

    function automatic logic [31:0] adv(input logic [31:0] st);
        for (int k = 0; k < GEN_N; k++) st = nxt(st);
        return st;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_ne(input string req, input logic [31:0] act, input logic [31:0] nope);
        checks++;
        if (act === nope) begin
            fails++;
            $display("FAIL %s actual=%h expected=not %h", req, act, nope);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        addr  = a;
        wdata = v;
        wr    = 1'b1;
        @(posedge clk);
        #1 wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] v, output logic [31:0] vz);
        @(negedge clk);
        addr = a;
        #1;
        v  = rdata;
        vz = rdata_z;
    endtask

    // issue a command, count busy cycles; optionally write once during the job
    task automatic run_cmd(input logic [31:0] cmd, input int inj_iter,
                           input logic [7:0] inj_addr, input logic [31:0] inj_data,
                           output int gen_n, output int seed_n);
        logic [31:0] s;
        gen_n  = 0;
        seed_n = 0;
        wr_reg(8'h00, cmd);
        for (int it = 1; it < 200; it++) begin
            @(negedge clk);
            wr   = 1'b0;
            addr = 8'h04;
            #1 s = rdata;
            if (s[30]) gen_n++;
            if (s[31]) seed_n++;
            if (!s[30] && !s[31]) break;
            if (it == inj_iter) begin
                addr  = inj_addr;
                wdata = inj_data;
                wr    = 1'b1;
            end
        end
    endtask

    task automatic wait_idle();
        logic [31:0] s, sz;
        for (int it = 0; it < 200; it++) begin
            rd_reg(8'h04, s, sz);
            if (!s[30] && !s[31]) break;
        end
    endtask

    logic [31:0] mstate;
    logic [31:0] exp_isr;
    logic        exp_wide, exp_seeded;

    function automatic logic [31:0] stat_idle();
        return (32'(exp_seeded) << 9) | (32'(exp_wide) << 3);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, vz, prev, ie, m;
        int g, s;
        void'($urandom(32'd1234));
        addr = 8'h00; wr = 1'b0; wdata = '0; rst_n = 1'b0;
        exp_isr = 0; exp_wide = 0; exp_seeded = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd_reg(8'h04, v, vz); check("R1 status", v, 32'h0);
        rd_reg(8'h08, v, vz); check("R1 mode", v, 32'h0);
        rd_reg(8'h10, v, vz); check("R1 ie", v, 32'h0);
        rd_reg(8'h14, v, vz); check("R1 isr", v, 32'h0);
        for (int i = 0; i < 8; i++) begin
            rd_reg(8'h20 + 8'(4*i), v, vz); check("R1 result", v, 32'h0);
        end
        check("R1 irq", 32'(irq), 32'h0);

        // R2 / R6 / R7 / R11 first generation, narrow mode
        mstate = SEED0;
        run_cmd(32'h1, 0, 8'h00, 32'h0, g, s);
        check("R2 generate length", 32'(g), 32'(GEN_N));
        check("R2 no seeding", 32'(s), 32'h0);
        rd_reg(8'h14, v, vz);
        check("R2 ready flag", v, 32'h1);
        check("R11 lockup flag on zero seed", vz & 32'h10, 32'h10);
        check("R11 no lockup on nonzero seed", v & 32'h10, 32'h0);
        exp_isr = 32'h1;
        for (int i = 0; i < 8; i++) begin
            rd_reg(8'h20 + 8'(4*i), v, vz);
            if (i < 4) begin
                check("R6 result word", v, word_after(mstate, i));
                check("R11 recovered word", vz, word_after(32'h0, i));
            end else begin
                check("R7 unused word zero", v, 32'h0);
            end
        end
        mstate = adv(mstate);

        // R4 no-op commands
        wr_reg(8'h00, 32'h0);
        rd_reg(8'h04, v, vz); check("R4 cmd 0 no busy", v, stat_idle());
        wr_reg(8'h00, 32'h3);
        rd_reg(8'h04, v, vz); check("R4 cmd 3 no busy", v, stat_idle());

        // R7 / R12 mode register keeps bit 3 only
        wr_reg(8'h08, 32'hFFFF_FFFF);
        exp_wide = 1;
        rd_reg(8'h08, v, vz); check("R12 mode bit3 only", v, 32'h8);
        rd_reg(8'h04, v, vz); check("R7 status mirrors wide", v, stat_idle());

        // R5 reseed command during generation ignored
        run_cmd(32'h1, 3, 8'h00, 32'h2, g, s);
        check("R5 generate length kept", 32'(g), 32'(GEN_N));
        check("R5 reseed not started", 32'(s), 32'h0);
        rd_reg(8'h04, v, vz); check("R5 not seeded", v, stat_idle());
        for (int i = 0; i < 8; i++) begin
            rd_reg(8'h20 + 8'(4*i), v, vz);
            check("R6 wide result word", v, word_after(mstate, i));
        end

        // R7 narrowing hides upper words, widening shows them again
        wr_reg(8'h08, 32'h0);
        rd_reg(8'h30, v, vz); check("R7 word4 hidden", v, 32'h0);
        rd_reg(8'h3C, v, vz); check("R7 word7 hidden", v, 32'h0);
        wr_reg(8'h08, 32'h8);
        rd_reg(8'h30, v, vz); check("R7 word4 back", v, word_after(mstate, 4));
        mstate = adv(mstate);

        // R8 results hold while generating, then all change
        rd_reg(8'h20, prev, vz);
        wr_reg(8'h00, 32'h1);
        for (int k = 0; k < 10; k++) begin
            rd_reg(8'h20, v, vz); check("R8 word0 holds", v, prev);
        end
        rd_reg(8'h3C, v, vz); check("R8 word7 holds", v, word_after(32'h0, 0) == 0 ? 32'h0 : v);
        wait_idle();
        rd_reg(8'h20, v, vz); check("R8 word0 updated", v, word_after(mstate, 0));
        rd_reg(8'h3C, v, vz); check("R8 word7 updated", v, word_after(mstate, 7));
        mstate = adv(mstate);

        // R9 clear all, then clear ready on its setting edge
        wr_reg(8'h14, 32'h13);
        rd_reg(8'h14, v, vz); check("R9 w1c all", v, 32'h0);
        run_cmd(32'h1, GEN_N, 8'h14, 32'h1, g, s);
        check("R2 generate length with clear", 32'(g), 32'(GEN_N));
        rd_reg(8'h14, v, vz); check("R9 set wins over clear", v, 32'h1);
        exp_isr = 32'h1;
        mstate = adv(mstate);

        // R3 reseed
        run_cmd(32'h2, 0, 8'h00, 32'h0, g, s);
        check("R3 reseed length", 32'(s), 32'(SEED_N));
        check("R3 no generating", 32'(g), 32'h0);
        exp_seeded = 1;
        rd_reg(8'h04, v, vz); check("R3 seeded status", v, stat_idle());
        rd_reg(8'h14, v, vz); check("R3 seed done flag", v, 32'h3);
        exp_isr = 32'h3;
        run_cmd(32'h1, 0, 8'h00, 32'h0, g, s);
        rd_reg(8'h20, v, vz); check_ne("R3 sequence changed", v, word_after(mstate, 0));

        // R10 directed irq
        wr_reg(8'h10, 32'h8000_0001);
        rd_reg(8'h10, v, vz); check("R10 irq on", 32'(irq), 32'h1);
        wr_reg(8'h10, 32'h0000_0013);
        rd_reg(8'h10, v, vz); check("R10 irq needs global", 32'(irq), 32'h0);

        // random mix
        for (int it = 0; it < 60; it++) begin
            case ($urandom % 4)
                0: begin
                    ie = $urandom;
                    wr_reg(8'h10, ie);
                    rd_reg(8'h10, v, vz);
                    check("R10 ie readback", v, ie & 32'h8000_0013);
                    check("R10 irq", 32'(irq),
                          32'(ie[31] & ((ie[0] & exp_isr[0]) | (ie[1] & exp_isr[1]) | (ie[4] & exp_isr[4]))));
                end
                1: begin
                    m = $urandom;
                    wr_reg(8'h14, m);
                    exp_isr = exp_isr & ~m & 32'h13;
                    rd_reg(8'h14, v, vz); check("R9 w1c random", v, exp_isr);
                end
                2: begin
                    logic [7:0] a;
                    m = $urandom;
                    case ($urandom % 3)
                        0: a = 8'h0C;
                        1: a = 8'h60;
                        default: a = 8'h64;
                    endcase
                    wr_reg(a, m);
                    rd_reg(a, v, vz); check("R12 scratch readback", v, m);
                    rd_reg(8'h04, v, vz); check("R12 status unaffected", v, stat_idle());
                end
                default: begin
                    logic [7:0] a;
                    case ($urandom % 4)
                        0: a = 8'h18;
                        1: a = 8'h1C;
                        2: a = 8'h40 + 8'(4 * ($urandom % 8));
                        default: a = 8'h68 + 8'(4 * ($urandom % 6));
                    endcase
                    rd_reg(a, v, vz); check("R13 unmapped reads zero", v, 32'h0);
                end
            endcase
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule